// File: doc/BRIEF.md
# Two-Bit-Per-Stage Asynchronous SAR Sequencer

This block is the digital control for a 6-bit successive-approximation converter that settles two result bits per step and needs only three steps per sample. Each step uses a bank of three comparators that fire in parallel against three reference taps of a resistor ladder. The sample clock runs at the conversion rate. The comparators evaluate while the clock is high and are held in reset while it is low. There is no faster internal clock. Each step is started by the completion strobe of the step before it, so the steps chain from the most significant pair down to the least significant pair.

The sequencer decodes each bank's three decisions, which form a thermometer code, into a bit pair. It raises the start trigger for the next bank. It drives one-hot tap selects for the second and third banks. The third-bank taps are preset as soon as the first bank finishes, so the ladder can settle while the second bank decides. The taps are then refined once the second bank has resolved. On the falling clock edge the sequencer registers the 6-bit code with a done flag, a bubble flag and a timeout flag. A bank that has not completed by then has its bits replaced by the midpoint of the window still unresolved.

Top module: `sar2b_async_seq`

## Requirements
- R1: With every strobe on time and every decision taken against the taps the block selects, the registered code equals the number of ladder taps (tap k stands at k/64 of full scale) that lie at or below the sampled level. The first bank uses the fixed taps 16, 32 and 48 and yields code bits 5:4. The second bank yields bits 3:2 and the third yields bits 1:0.
- R2: Each bank's decision vector has bit 0 against its lowest tap and bit 2 against its highest. Its bit pair equals the number of ones in the vector.
- R3: The bubble output is high for a conversion in which any completed bank reported a pattern other than 000, 001, 011 or 111.
- R4: `trig2` is high only while the clock is high and after the first bank's strobe. `trig3` additionally requires the second bank's strobe. A second-bank strobe that arrives without a first-bank strobe has no effect.
- R5: Once the first bank completes with pair q, the second-bank selects are one-hot, with bit k-1 standing for tap k. They pick taps 16q+4, 16q+8 and 16q+12 on the lo, mid and hi outputs.
- R6: From the first bank's completion until the second bank's completion, the third-bank selects preset taps 16q+9, 16q+10 and 16q+11. After the second bank completes with pair r, they pick 16q+4r+1, +2 and +3.
- R7: While the clock is low, both triggers and all six select vectors are zero.
- R8: A bank without a strobe by the falling edge raises the timeout output. Its bits and all lower bits become a 1 followed by zeros: 100000, qq1000 or qqrr10.
- R9: The code, done, bubble and timeout are registered on the falling edge and hold through the following high phase.
- R10: Reset is synchronous, active low and sampled on the falling edge. It clears the code, done, bubble and timeout to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; high phase evaluates, low phase resets the comparators |
| rst_n | input | 1 | Synchronous active-low reset |
| s1_dec | input | 3 | First-bank decisions, bit 0 against the lowest tap |
| s1_done | input | 1 | First-bank completion strobe |
| s2_dec | input | 3 | Second-bank decisions |
| s2_done | input | 1 | Second-bank completion strobe |
| s3_dec | input | 3 | Third-bank decisions |
| s3_done | input | 1 | Third-bank completion strobe |
| trig2 | output | 1 | Start trigger for the second bank |
| trig3 | output | 1 | Start trigger for the third bank |
| ref2_sel_lo | output | 63 | One-hot tap select, second bank low comparator |
| ref2_sel_mid | output | 63 | One-hot tap select, second bank middle comparator |
| ref2_sel_hi | output | 63 | One-hot tap select, second bank high comparator |
| ref3_sel_lo | output | 63 | One-hot tap select, third bank low comparator |
| ref3_sel_mid | output | 63 | One-hot tap select, third bank middle comparator |
| ref3_sel_hi | output | 63 | One-hot tap select, third bank high comparator |
| code | output | 6 | Registered conversion result |
| done | output | 1 | Registered result-valid flag |
| bubble | output | 1 | Registered non-thermometer decision flag |
| timeout | output | 1 | Registered missing-strobe flag |

## Verification
The assertions assume the following about the inputs. A strobe, once raised, stays high until the clock falls. Decisions are stable whenever their strobe is high. All strobes are low again during the low phase. Under these assumptions the triggers, selects and registered flags can be related at the clock edges. The stimulus respects this by raising each bank's decisions and strobe a few hundred picoseconds apart within the high phase and clearing them just after the falling edge. Timeouts are produced by withholding a strobe, never by letting it cross the edge, so the edge never samples a strobe that is changing.

// File: rtl/sar2b_pkg.sv
// Shared constants for the two-bit-per-stage SAR sequencer.
// Assumes a 6-bit result split into three two-bit banks.
package sar2b_pkg;
    localparam int RES_BITS  = 6;
    localparam int PAIR_BITS = 2;
    localparam int NUM_BANKS = RES_BITS / PAIR_BITS;
    localparam int NUM_CMP   = (1 << PAIR_BITS) - 1;
    localparam int NUM_TAPS  = (1 << RES_BITS) - 1;
endpackage

// File: rtl/sar2b_stage_decode.sv
// Converts one bank's thermometer-coded decisions into a bit pair.
// The pair is the number of ones, so a bubble resolves by counting.
// Flags any pattern that is not a clean thermometer code.
// Assumes bit 0 of dec is the comparator against the lowest tap.
module sar2b_stage_decode #(
    parameter int NCMP = 3,
    parameter int PW   = 2
) (
    input  logic [NCMP-1:0] dec,
    output logic [PW-1:0]   pair,
    output logic            bubble
);
    logic [PW-1:0] ones;

    // Count the ones in the decision vector.
    always_comb begin
        ones = '0;
        for (int i = 0; i < NCMP; i++) begin
            ones = ones + PW'(dec[i]);
        end
    end

    // A legal code is a run of ones starting at bit 0.
    always_comb begin
        pair   = ones;
        bubble = (dec != NCMP'((1 << ones) - 1));
    end
endmodule

// File: rtl/sar2b_tap_select.sv
// Generates one one-hot ladder-tap select per comparator of a bank.
// Comparator i is steered to tap base + step*(i+1); bit k-1 marks tap k.
// All selects are zero while en is low.
// Assumes base + step*NCMP never exceeds NTAPS.
module sar2b_tap_select #(
    parameter int NTAPS = 63,
    parameter int NCMP  = 3,
    parameter int BW    = 6
) (
    input  logic                        en,
    input  logic [BW-1:0]               base,
    input  logic [BW-1:0]               step,
    output logic [NCMP-1:0][NTAPS-1:0]  sel
);
    localparam int IW = BW + 2;

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        logic [IW-1:0] idx;
        // Tap index for comparator i.
        assign idx    = IW'(base) + IW'(step) * IW'(i + 1);
        // Decode the index into a one-hot select, gated by enable.
        assign sel[i] = en ? (NTAPS'(1) << (idx - IW'(1))) : '0;
    end
endmodule

// File: rtl/sar2b_result_reg.sv
// Captures the resolved code and flags on the falling clock edge.
// The outputs hold through the following high phase.
// The reset is synchronous, active low, and sampled on the same edge.
module sar2b_result_reg #(
    parameter int NBITS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] code_in,
    input  logic             bubble_in,
    input  logic             timeout_in,
    output logic [NBITS-1:0] code,
    output logic             done,
    output logic             bubble,
    output logic             timeout
);
    // Register the result of the phase that just ended.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            code    <= '0;
            done    <= 1'b0;
            bubble  <= 1'b0;
            timeout <= 1'b0;
        end else begin
            code    <= code_in;
            done    <= 1'b1;
            bubble  <= bubble_in;
            timeout <= timeout_in;
        end
    end

    // R8: a midpoint fill always ends in a zero bit 0.
    p_timeout_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (code[0] == 1'b0));

    // R9: a result with any flag set also carries done.
    p_flag_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bubble || timeout) |-> done);
endmodule

// File: rtl/sar2b_async_seq.sv
// Sequencer for a 6-bit converter that resolves two bits per bank.
// The three banks chain on their strobes: bank 1 starts on the rising
// clock, and each later bank is triggered by the completion of the one
// before it. The third-bank taps are preset when bank 1 finishes and
// refined when bank 2 finishes. Banks that miss the falling edge are
// filled with the midpoint of the window still open.
// Assumes strobes stay high until the clock falls and are low while it is low.
module sar2b_async_seq
    import sar2b_pkg::*;
#(
    parameter int NBITS = RES_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           s1_dec,
    input  logic                 s1_done,
    input  logic [2:0]           s2_dec,
    input  logic                 s2_done,
    input  logic [2:0]           s3_dec,
    input  logic                 s3_done,
    output logic                 trig2,
    output logic                 trig3,
    output logic [62:0]          ref2_sel_lo,
    output logic [62:0]          ref2_sel_mid,
    output logic [62:0]          ref2_sel_hi,
    output logic [62:0]          ref3_sel_lo,
    output logic [62:0]          ref3_sel_mid,
    output logic [62:0]          ref3_sel_hi,
    output logic [NBITS-1:0]     code,
    output logic                 done,
    output logic                 bubble,
    output logic                 timeout
);
    localparam int NB    = NUM_BANKS;
    localparam int NC    = NUM_CMP;
    localparam int PW    = PAIR_BITS;
    localparam int NT    = NUM_TAPS;
    localparam int STEP2 = 1 << (NBITS - 2 * PW);
    localparam int STEP3 = 1;
    localparam logic [PW-1:0] PRESET_PAIR = PW'(1 << (PW - 1));

    logic [NC-1:0] dec_all [NB];
    logic [PW-1:0] pair    [NB];
    logic [NB-1:0] bub_raw;
    logic [NB-1:0] chain;
    logic [PW-1:0] sub3;
    logic [NBITS-1:0] base2, base3;
    logic [NC-1:0][NT-1:0] sel2, sel3;
    logic [NBITS-1:0] res_code;
    logic res_bub, res_to;

    // Bundle the bank decisions for the generated decoders.
    assign dec_all[0] = s1_dec;
    assign dec_all[1] = s2_dec;
    assign dec_all[2] = s3_dec;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        sar2b_stage_decode #(.NCMP(NC), .PW(PW)) u_dec (
            .dec    (dec_all[b]),
            .pair   (pair[b]),
            .bubble (bub_raw[b])
        );
    end

    // Completion chain: a bank counts only after all banks above it.
    always_comb begin
        chain[0] = s1_done;
        chain[1] = s1_done & s2_done;
        chain[2] = s1_done & s2_done & s3_done;
    end

    // Triggers exist only in the evaluation phase.
    assign trig2 = clk & chain[0];
    assign trig3 = clk & chain[1];

    // Reference windows: the bank-2 quarter, and the bank-3 sixteenth, which is preset until bank 2 resolves.
    assign sub3  = chain[1] ? pair[1] : PRESET_PAIR;
    assign base2 = {pair[0], {(NBITS - PW){1'b0}}};
    assign base3 = {pair[0], sub3, {(NBITS - 2 * PW){1'b0}}};

    sar2b_tap_select #(.NTAPS(NT), .NCMP(NC), .BW(NBITS)) u_sel2 (
        .en   (trig2),
        .base (base2),
        .step (NBITS'(STEP2)),
        .sel  (sel2)
    );

    sar2b_tap_select #(.NTAPS(NT), .NCMP(NC), .BW(NBITS)) u_sel3 (
        .en   (trig2),
        .base (base3),
        .step (NBITS'(STEP3)),
        .sel  (sel3)
    );

    assign ref2_sel_lo  = sel2[0];
    assign ref2_sel_mid = sel2[1];
    assign ref2_sel_hi  = sel2[2];
    assign ref3_sel_lo  = sel3[0];
    assign ref3_sel_mid = sel3[1];
    assign ref3_sel_hi  = sel3[2];

    // Resolve the code, filling unfinished banks with the window midpoint.
    always_comb begin
        res_code = {1'b1, {(NBITS - 1){1'b0}}};
        if (chain[2]) begin
            res_code = {pair[0], pair[1], pair[2]};
        end else if (chain[1]) begin
            res_code = {pair[0], pair[1], 2'b10};
        end else if (chain[0]) begin
            res_code = {pair[0], 4'b1000};
        end
        res_to  = ~chain[2];
        res_bub = |(chain & bub_raw);
    end

    sar2b_result_reg #(.NBITS(NBITS)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_in    (res_code),
        .bubble_in  (res_bub),
        .timeout_in (res_to),
        .code       (code),
        .done       (done),
        .bubble     (bubble),
        .timeout    (timeout)
    );

    // R4: bank 3 is never started ahead of bank 2.
    p_trig_order_r4: assert property (@(negedge clk) disable iff (!rst_n)
        trig3 |-> trig2);

    // R6: the bank-3 middle tap lies inside the quarter picked by bank 1.
    p_ref3_in_quarter_r6: assert property (@(negedge clk) disable iff (!rst_n)
        trig2 |-> ((ref3_sel_mid & (NT'(16'h7FFF) << (16 * pair[0]))) != '0));

    // R7: the low phase drives no reference select.
    p_sel_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref2_sel_mid == '0) && (ref3_sel_mid == '0) && !trig2);
endmodule

// File: tb/sar2b_async_seq_tb.sv
`timescale 1ns/1ps
module sar2b_async_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] s1_dec = '0, s2_dec = '0, s3_dec = '0;
    logic s1_done = 1'b0, s2_done = 1'b0, s3_done = 1'b0;
    logic trig2, trig3;
    logic [62:0] r2l, r2m, r2h, r3l, r3m, r3h;
    logic [5:0] code;
    logic done, bubble, timeout;

    typedef struct { int code; int bub; int to; } exp_t;
    exp_t q[$];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sar2b_async_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .s1_dec(s1_dec), .s1_done(s1_done),
        .s2_dec(s2_dec), .s2_done(s2_done),
        .s3_dec(s3_dec), .s3_done(s3_done),
        .trig2(trig2), .trig3(trig3),
        .ref2_sel_lo(r2l), .ref2_sel_mid(r2m), .ref2_sel_hi(r2h),
        .ref3_sel_lo(r3l), .ref3_sel_mid(r3m), .ref3_sel_hi(r3h),
        .code(code), .done(done), .bubble(bubble), .timeout(timeout)
    );

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int tap_of(input logic [62:0] s);
        for (int i = 0; i < 63; i++) if (s[i]) return i + 1;
        return 0;
    endfunction

    function automatic logic [2:0] cmp3(input int v, input int a, input int b, input int c);
        return {logic'(v >= c), logic'(v >= b), logic'(v >= a)};
    endfunction

    // Driver: one conversion. Banks numbered >= stop_at never strobe.
    task automatic convert(input int v, input int stop_at, input bit frc,
                           input logic [2:0] pat, input bit early2);
        int c1, c2, rem, e_code, e_bub;
        logic [2:0] d1;
        d1 = frc ? pat : cmp3(v, 16, 32, 48);
        c1 = $countones(d1);
        rem = v - c1 * 16;
        if (rem < 0) rem = 0;
        if (rem > 15) rem = 15;
        c2 = rem / 4;
        e_bub = (stop_at > 1) && !(d1 == 3'b000 || d1 == 3'b001 || d1 == 3'b011 || d1 == 3'b111);
        if (stop_at == 1) e_code = 32;
        else if (stop_at == 2) e_code = c1 * 16 + 8;
        else if (stop_at == 3) e_code = c1 * 16 + c2 * 4 + 2;
        else e_code = c1 * 16 + rem;
        @(posedge clk);
        q.push_back('{e_code, e_bub, (stop_at < 4)});
        #0.2;
        if (stop_at > 1) begin
            s1_dec = d1; s1_done = 1'b1;
        end else if (early2) begin
            s2_dec = 3'b111; s2_done = 1'b1;
        end
        #0.3;
        if (early2) chk("R4 lone bank-2 strobe trig2", trig2, 0);
        if (stop_at > 1) begin
            chk("R4 trig2 after bank 1", trig2, 1);
            chk("R4 trig3 before bank 2", trig3, 0);
            chk("R5 ref2 lo", tap_of(r2l), c1 * 16 + 4);
            chk("R5 ref2 mid", tap_of(r2m), c1 * 16 + 8);
            chk("R5 ref2 hi", tap_of(r2h), c1 * 16 + 12);
            chk("R6 ref3 preset lo", tap_of(r3l), c1 * 16 + 9);
            chk("R6 ref3 preset hi", tap_of(r3h), c1 * 16 + 11);
        end
        if (stop_at > 2) begin
            s2_dec = cmp3(v, tap_of(r2l), tap_of(r2m), tap_of(r2h));
            s2_done = 1'b1;
            #0.3;
            chk("R4 trig3 after bank 2", trig3, 1);
            chk("R6 ref3 refined mid", tap_of(r3m), c1 * 16 + c2 * 4 + 2);
        end
        if (stop_at > 3) begin
            s3_dec = cmp3(v, tap_of(r3l), tap_of(r3m), tap_of(r3h));
            s3_done = 1'b1;
        end
        @(negedge clk);
        #0.2;
        s1_done = 0; s2_done = 0; s3_done = 0;
        s1_dec = '0; s2_dec = '0; s3_dec = '0;
        #0.2;
        chk("R7 low-phase trig2", trig2, 0);
        chk("R7 low-phase selects", int'((r2l | r2m | r2h | r3l | r3m | r3h) != '0), 0);
    endtask

    // Monitor: compare each registered result, then confirm it holds.
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                chk("R1/R8 code", code, it.code);
                chk("R9 done", done, 1);
                chk("R3 bubble", bubble, it.bub);
                chk("R8 timeout", timeout, it.to);
                @(posedge clk);
                #1;
                chk("R9 code held", code, it.code);
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R10 reset code", code, 0);
        chk("R10 reset done", done, 0);
        chk("R10 reset flags", int'(bubble | timeout), 0);
        rst_n = 1'b1;
        // R1, R2: every level with all banks on time
        for (int v = 0; v < 64; v++) convert(v, 4, 0, 3'b000, 0);
        // R3: bubbles resolve by count; a legal forced pattern stays clean
        convert(40, 4, 1, 3'b010, 0);
        convert(10, 4, 1, 3'b101, 0);
        convert(5, 4, 1, 3'b111, 0);
        // R8: missing strobes at each bank
        convert(45, 1, 0, 3'b000, 0);
        convert(45, 2, 0, 3'b000, 0);
        convert(45, 3, 0, 3'b000, 0);
        convert(13, 3, 0, 3'b000, 0);
        // R4: bank-2 strobe without bank 1 is ignored
        convert(60, 1, 0, 3'b000, 1);
        repeat (4) @(negedge clk);
        #2;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule